// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single transactions on the two-wire PHY management bus. A host presents one request at a time: a read or write flag, a 5-bit PHY address, a register address and, for writes, 16 bits of data, and pulses `req_start`. The master then produces the management clock `mdc` from the system clock and drives the data line through an output/enable pair (`mdio_o`, `mdio_oe`). A read returns 16 bits on `rd_data`, which are sampled from `mdio_i`. Each transaction starts with a long run of ones so that the PHY can synchronise. Turnaround and trailing clocks are sent with the line released.

Each bit occupies one MDC period, called a slot here: MDC is low for the first half and high for the second. New data goes onto the line at the edge that takes MDC low, and read data is sampled in the last system cycle before MDC rises. The controller has five states. `ST_IDLE` goes to `ST_PRE` when a request is accepted. `ST_PRE` goes to `ST_CMD` after 33 slots. `ST_CMD` goes to `ST_RX` for a read after 16 slots, or to `ST_TAIL` for a write after 32 slots. `ST_RX` goes back to `ST_IDLE` after 19 slots, and `ST_TAIL` does so after 2 slots. A write request with an illegal register address is turned away in `ST_IDLE` and never leaves it.

Top module: `mdio_master`

## Requirements
- R1: After reset, `busy`, `done`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.
- R2: MDC is high for exactly HALF system cycles and low for exactly HALF system cycles within a transaction, where HALF = ceil(SYS_CLK_HZ / (2*MDC_MAX_HZ)), so MDC never exceeds MDC_MAX_HZ (HALF = 2 at the default parameters). MDC is low whenever `busy` is 0.
- R3: Every transaction that is accepted begins with 33 slots in which `mdio_oe`=1 and `mdio_o`=1.
- R4: After the ones, a read drives 16 slots, MSB first: 1,1,0,1,1,0, then the PHY address bits 4..0, then the register address bits 4..0.
- R5: A read then releases the line (`mdio_oe`=0) for 19 slots and samples `mdio_i` once per slot, just before MDC rises. `rd_data` takes samples 3 through 18, with the third sample as bit 15 and the eighteenth as bit 0. The first two samples and the last one are discarded. `rd_data` is valid in the cycle that `done` is high.
- R6: After the ones, a write drives 32 slots, MSB first: 0,1,0,1, the PHY address bits 4..0, the register address bits 4..0, 1,0, then the write data bits 15..0.
- R7: A write ends with 2 released slots before `done`. A write frame therefore has 67 MDC rising edges and a read frame has 68.
- R8: `mdio_o` and `mdio_oe` change only while MDC is low, and they hold their values at and during each MDC high phase.
- R9: A write request whose register address has any bit above bit 4 set is rejected. `busy` stays 0, MDC does not toggle, `mdio_oe` stays 0, and `done` pulses for one cycle in the next cycle.
- R10: A read uses only register address bits 4..0. Bits above bit 4 have no effect on the frame.
- R11: `busy` is 1 from the cycle after a request is accepted until the cycle in which `done` pulses. `done` is high for one cycle per request. A `req_start` while `busy` is 1 is ignored.
- R12: `rd_data` changes only at the end of a read. Writes and rejected requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_W (8) | Register address; bits above 4 make a write illegal |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench records the line at every MDC rising edge and compares the preamble, command and released slots against a frame it builds from the request. A design that is off by one in any phase shows up as the wrong number of rising edges (67 or 68) or as a shifted command field. The PHY model drives distinct turnaround values and a data word with an asymmetric pattern. A capture window shifted by one slot would therefore return a visibly rotated word, and a missing discard of the last bit would do the same. Directed cases cover three things: an illegal write address that must produce no clock at all, a read with high address bits set that must still send a clean 5-bit field, and a second strobe during a frame that must neither corrupt nor restart it. The bench also times every MDC phase and checks that no data change falls inside a high phase.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_CMD,
        ST_RX,
        ST_TAIL
    } mdio_state_e;

    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 16;
    localparam int PRE_SLOTS    = 33;
    localparam int RD_CMD_SLOTS = 16;
    localparam int WR_CMD_SLOTS = 32;
    localparam int RX_SLOTS     = 19;
    localparam int RX_LEAD      = 2;
    localparam int TAIL_SLOTS   = 2;

    // Read command: two extra ones, start, read opcode, addresses.
    function automatic logic [RD_CMD_SLOTS-1:0] rd_word(
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rg
    );
        return {2'b11, 2'b01, 2'b10, phy, rg};
    endfunction

    // Write command: start, write opcode, addresses, turnaround, data.
    function automatic logic [WR_CMD_SLOTS-1:0] wr_word(
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rg,
        input logic [DATA_W-1:0] data
    );
        return {2'b01, 2'b01, phy, rg, 2'b10, data};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic sample_stb,
    output logic slot_end
);
    localparam int PERIOD = 2 * HALF;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else begin
            if (cnt_q == CW'(PERIOD - 1)) begin
                cnt_q <= '0;
                mdc   <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(HALF - 1)) begin
                    mdc <= 1'b1;
                end
            end
        end
    end

    assign sample_stb = run && (cnt_q == CW'(HALF - 1));
    assign slot_end   = run && (cnt_q == CW'(PERIOD - 1));

    // Independent run-length counter for the high phase.
    int unsigned hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   hi_run_q <= 0;
        else if (mdc) hi_run_q <= hi_run_q + 1;
        else          hi_run_q <= 0;
    end

    // R2: high phase never longer than HALF cycles
    a_r2_mdc_high_len: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> (hi_run_q < HALF));

    // R2: clock parks low when not running
    a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= load_word;
        else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign msb = sh_q[W-1];

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
    parameter int W     = 16,
    parameter int LEAD  = 2,
    parameter int TOTAL = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         sample,
    input  logic         din,
    output logic [W-1:0] word
);
    localparam int IW = $clog2(TOTAL + 1);

    logic [IW-1:0] idx_q;
    logic          keep;

    // Only samples LEAD .. LEAD+W-1 are kept; the others are discarded.
    assign keep = (idx_q >= IW'(LEAD)) && (idx_q < IW'(LEAD + W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            word  <= '0;
        end else if (clear) begin
            idx_q <= '0;
            word  <= '0;
        end else if (sample) begin
            idx_q <= idx_q + 1'b1;
            if (keep) begin
                word <= {word[W-2:0], din};
            end
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SYS_CLK_HZ = 10_000_000,
    parameter int MDC_MAX_HZ = 2_500_000,
    parameter int REG_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [4:0]        req_phy,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [15:0]       req_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int HALF_RAW = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int SLOT_W   = $clog2(PRE_SLOTS + 1);

    mdio_state_e       state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] phase_last;
    logic              phase_end;
    logic              is_wr_q;
    logic              done_q;
    logic [DATA_W-1:0] rd_q;

    logic              run;
    logic              sample_stb;
    logic              slot_end;
    logic              tx_msb;
    logic              rx_sample;
    logic [DATA_W-1:0] rx_word;
    logic [WR_CMD_SLOTS-1:0] cmd_word;

    logic addr_high;
    logic accept;
    logic reject;

    assign addr_high = (req_reg >> ADDR_W) != '0;
    assign accept    = (state_q == ST_IDLE) && req_start && !(req_write && addr_high);
    assign reject    = (state_q == ST_IDLE) && req_start && req_write && addr_high;

    assign cmd_word = req_write
        ? wr_word(req_phy, req_reg[ADDR_W-1:0], req_wdata)
        : {rd_word(req_phy, req_reg[ADDR_W-1:0]), {(WR_CMD_SLOTS - RD_CMD_SLOTS){1'b0}}};

    assign run = (state_q != ST_IDLE);

    mdio_mdc_gen #(.HALF(HALF)) u_mdc (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .mdc        (mdc),
        .sample_stb (sample_stb),
        .slot_end   (slot_end)
    );

    mdio_tx_shift #(.W(WR_CMD_SLOTS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (cmd_word),
        .shift     (slot_end && (state_q == ST_CMD)),
        .msb       (tx_msb)
    );

    assign rx_sample = (state_q == ST_RX) && sample_stb;

    mdio_rx_shift #(.W(DATA_W), .LEAD(RX_LEAD), .TOTAL(RX_SLOTS)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .sample (rx_sample),
        .din    (mdio_i),
        .word   (rx_word)
    );

    // Length of the current phase, in slots, minus one.
    always_comb begin
        unique case (state_q)
            ST_PRE:  phase_last = SLOT_W'(PRE_SLOTS - 1);
            ST_CMD:  phase_last = is_wr_q ? SLOT_W'(WR_CMD_SLOTS - 1)
                                          : SLOT_W'(RD_CMD_SLOTS - 1);
            ST_RX:   phase_last = SLOT_W'(RX_SLOTS - 1);
            ST_TAIL: phase_last = SLOT_W'(TAIL_SLOTS - 1);
            default: phase_last = '0;
        endcase
    end

    assign phase_end = slot_end && (slot_q == phase_last);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ST_PRE;
            ST_PRE:  if (phase_end) state_d = ST_CMD;
            ST_CMD:  if (phase_end) state_d = is_wr_q ? ST_TAIL : ST_RX;
            ST_RX:   if (phase_end) state_d = ST_IDLE;
            ST_TAIL: if (phase_end) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Slot counter within the current phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (accept) begin
            slot_q <= '0;
        end else if (slot_end) begin
            slot_q <= phase_end ? '0 : slot_q + 1'b1;
        end
    end

    // Request flag, completion pulse and returned data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q <= 1'b0;
            done_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            if (accept) is_wr_q <= req_write;
            done_q <= reject ||
                      (((state_q == ST_RX) || (state_q == ST_TAIL)) && phase_end);
            if ((state_q == ST_RX) && phase_end) rd_q <= rx_word;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_PRE: begin
                mdio_oe = 1'b1;
                mdio_o  = 1'b1;
            end
            ST_CMD: begin
                mdio_oe = 1'b1;
                mdio_o  = tx_msb;
            end
            default: begin
                mdio_oe = 1'b0;
                mdio_o  = 1'b0;
            end
        endcase
    end

    assign done    = done_q;
    assign rd_data = rd_q;

    // R1: idle means released line and parked clock
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));

    // R8: line value and enable are steady across each MDC rise
    a_r8_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R5: input sampled only with MDC low and the line released
    a_r5_sample_low: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |-> (!mdc && !mdio_oe));

    // R9: illegal write address produces a bare done pulse
    a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start && req_write && addr_high) |=> (done && !busy && !mdc));

    // R11: completion is reported only with busy low
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11: a request in flight cannot be replaced
    a_r11_req_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(is_wr_q)));

endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;

    localparam int CLK_PERIOD = 100;
    localparam int HALF       = 2;
    localparam int MAX_SLOTS  = 80;
    localparam int NVEC       = 6;

    // {write, phy[4:0], reg[7:0], data[15:0]}; data is write data or PHY reply
    localparam logic [29:0] VEC [NVEC] = '{
        {1'b0, 5'h01, 8'h01, 16'h796D},
        {1'b1, 5'h1F, 8'h04, 16'h01E1},
        {1'b0, 5'h00, 8'h1F, 16'h8001},
        {1'b1, 5'h00, 8'h00, 16'h0000},
        {1'b0, 5'h15, 8'h02, 16'hFFFF},
        {1'b1, 5'h0A, 8'h1F, 16'hA5A5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [7:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rd_data;
    logic        phy_bit = 1'b1;

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_bit;

    mdio_master u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_start (req_start),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Line monitor and PHY model state
    int          nrise = 0;
    int          done_cnt = 0;
    int          done_wide = 0;
    int          hold_err = 0;
    int          period_err = 0;
    int          run_len = 0;
    logic        mdc_prev = 1'b0;
    logic        o_prev = 1'b0;
    logic        done_prev = 1'b0;
    logic        seen_high = 1'b0;
    logic [15:0] phy_resp = '0;
    logic        rec_o  [MAX_SLOTS];
    logic        rec_oe [MAX_SLOTS];
    logic        exp_o  [MAX_SLOTS];
    logic        exp_oe [MAX_SLOTS];
    int          exp_len = 0;

    function automatic logic resp_bit(input int j, input logic [15:0] r);
        if (j == 49)                return 1'b1;
        else if (j == 50)           return 1'b0;
        else if (j >= 51 && j <= 66) return r[66 - j];
        else                        return 1'b1;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc && !mdc_prev) begin
                if (nrise < MAX_SLOTS) begin
                    rec_o[nrise]  = mdio_o;
                    rec_oe[nrise] = mdio_oe;
                end
                nrise++;
            end
            if (mdc && mdc_prev && (mdio_o != o_prev)) hold_err++;
            if (mdc != mdc_prev) begin
                if (mdc_prev && run_len != HALF) period_err++;
                if (!mdc_prev && seen_high && run_len != HALF) period_err++;
                if (mdc) seen_high = 1'b1;
                run_len = 1;
            end else begin
                run_len++;
            end
            if (!busy && !mdc) seen_high = 1'b0;
            if (done) done_cnt++;
            if (done && done_prev) done_wide++;
            if (!mdc) phy_bit = resp_bit(nrise, phy_resp);
            mdc_prev  = mdc;
            o_prev    = mdio_o;
            done_prev = done;
        end
    end

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected below 150000", cyc);
            report();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic build_exp(input logic wr, input logic [4:0] phy,
                             input logic [7:0] rg, input logic [15:0] data);
        logic [31:0] w;
        logic [15:0] r;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            exp_o[i]  = 1'b0;
            exp_oe[i] = 1'b0;
        end
        for (int i = 0; i < 33; i++) begin
            exp_o[i]  = 1'b1;
            exp_oe[i] = 1'b1;
        end
        if (wr) begin
            w = {4'b0101, phy, rg[4:0], 2'b10, data};
            for (int i = 0; i < 32; i++) begin
                exp_o[33 + i]  = w[31 - i];
                exp_oe[33 + i] = 1'b1;
            end
            exp_len = 67;
        end else begin
            r = {6'b110110, phy, rg[4:0]};
            for (int i = 0; i < 16; i++) begin
                exp_o[33 + i]  = r[15 - i];
                exp_oe[33 + i] = 1'b1;
            end
            exp_len = 68;
        end
    endtask

    function automatic int slot_errs(input int lo, input int hi);
        int e = 0;
        for (int i = lo; i < hi; i++) begin
            if (rec_oe[i] !== exp_oe[i]) e++;
            else if (exp_oe[i] && rec_o[i] !== exp_o[i]) e++;
        end
        return e;
    endfunction

    task automatic run_txn(input logic wr, input logic [4:0] phy,
                           input logic [7:0] rg, input logic [15:0] data,
                           input int poke, output logic busy_seen);
        @(negedge clk);
        phy_resp   = data;
        nrise      = 0;
        done_cnt   = 0;
        done_wide  = 0;
        hold_err   = 0;
        period_err = 0;
        req_start  = 1'b1;
        req_write  = wr;
        req_phy    = phy;
        req_reg    = rg;
        req_wdata  = data;
        @(negedge clk);
        req_start = 1'b0;
        busy_seen = busy;
        for (int c = 1; c < 4000; c++) begin
            @(negedge clk);
            if (poke > 0 && c == poke) begin
                req_start = 1'b1;
                req_write = 1'b1;
                req_phy   = 5'h07;
                req_reg   = 8'h02;
                req_wdata = 16'hBEEF;
            end else begin
                req_start = 1'b0;
            end
            if (done) break;
        end
        req_start = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_frame(input logic wr, input logic [15:0] data,
                               input logic [15:0] last_rd, input logic busy_seen,
                               input string tag);
        int cmd_n;
        cmd_n = wr ? 32 : 16;
        check(nrise == exp_len, wr ? "R7" : "R7", {tag, " rising edge count"}, nrise, exp_len);
        check(slot_errs(0, 33) == 0, "R3", {tag, " preamble slots"}, slot_errs(0, 33), 0);
        if (wr) begin
            check(slot_errs(33, 65) == 0, "R6", {tag, " write command"}, slot_errs(33, 65), 0);
            check(slot_errs(65, 67) == 0, "R7", {tag, " released tail"}, slot_errs(65, 67), 0);
            check(rd_data == last_rd, "R12", {tag, " rd_data kept over write"}, rd_data, last_rd);
        end else begin
            check(slot_errs(33, 33 + cmd_n) == 0, "R4", {tag, " read command"},
                  slot_errs(33, 49), 0);
            check(slot_errs(49, 68) == 0, "R5", {tag, " released read slots"}, slot_errs(49, 68), 0);
            check(rd_data == data, "R5", {tag, " read data"}, rd_data, data);
        end
        check(done_cnt == 1 && done_wide == 0, "R11", {tag, " single done pulse"}, done_cnt, 1);
        check(busy_seen && !busy, "R11", {tag, " busy window"}, {busy_seen, busy}, 2'b10);
        check(hold_err == 0, "R8", {tag, " data steady while MDC high"}, hold_err, 0);
        check(period_err == 0, "R2", {tag, " MDC phase lengths"}, period_err, 0);
    endtask

    initial begin
        logic        bs;
        logic [15:0] last_rd;
        int          rises_before;
        bit          saw_busy;
        bit          saw_oe;
        last_rd = 16'h0000;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1", "busy/done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!mdc && !mdio_oe, "R1", "mdc/oe after reset", {mdc, mdio_oe}, 0);
        check(rd_data == 16'h0, "R1", "rd_data after reset", rd_data, 0);
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);

        // Table of requests
        for (int v = 0; v < NVEC; v++) begin
            build_exp(VEC[v][29], VEC[v][28:24], VEC[v][23:16], VEC[v][15:0]);
            run_txn(VEC[v][29], VEC[v][28:24], VEC[v][23:16], VEC[v][15:0], 0, bs);
            check_frame(VEC[v][29], VEC[v][15:0], last_rd, bs, $sformatf("vec%0d", v));
            if (!VEC[v][29]) last_rd = VEC[v][15:0];
        end

        // R9: write with register address above 31 is rejected
        @(negedge clk);
        rises_before = nrise;
        req_start = 1'b1;
        req_write = 1'b1;
        req_phy   = 5'h03;
        req_reg   = 8'h20;
        req_wdata = 16'h1234;
        @(negedge clk);
        req_start = 1'b0;
        check(done && !busy, "R9", "reject done pulse", {done, busy}, 2'b10);
        saw_busy = 1'b0;
        saw_oe   = 1'b0;
        @(negedge clk);
        check(!done, "R9", "reject done one cycle", done, 0);
        for (int k = 0; k < 20; k++) begin
            if (busy) saw_busy = 1'b1;
            if (mdio_oe) saw_oe = 1'b1;
            @(negedge clk);
        end
        check(!saw_busy && !saw_oe, "R9", "no bus activity", {saw_busy, saw_oe}, 0);
        check(nrise == rises_before, "R9", "no MDC edges", nrise, rises_before);
        check(rd_data == last_rd, "R12", "rd_data kept over reject", rd_data, last_rd);

        // R10: read ignores register address bits above 4
        build_exp(1'b0, 5'h02, 8'hE3, 16'h4C31);
        run_txn(1'b0, 5'h02, 8'hE3, 16'h4C31, 0, bs);
        check(slot_errs(33, 49) == 0, "R10", "read field uses low 5 bits",
              slot_errs(33, 49), 0);
        check(rd_data == 16'h4C31, "R10", "read data with high bits", rd_data, 16'h4C31);
        last_rd = 16'h4C31;

        // R11: second strobe during a read is ignored
        build_exp(1'b0, 5'h03, 8'h01, 16'h1234);
        run_txn(1'b0, 5'h03, 8'h01, 16'h1234, 100, bs);
        check_frame(1'b0, 16'h1234, last_rd, bs, "R11 strobe while busy");

        report();
        $finish;
    end

endmodule